// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the program counter for the next instruction of a 32-bit single-issue core and holds that counter in a register. From the opcode and function fields, the immediate, the jump target and the two source register values, it decides whether the next instruction comes from sequential flow, a conditional branch, an absolute jump or a register-indirect jump. An exception request overrides all of these and sends fetch to a fixed vector.

For the two link forms, the block also produces the write request for the return address. This consists of the destination register number and a data value equal to the current PC plus 8. The register file, the ALU and instruction fetch lie outside the block. The caller decodes the fields and supplies the operand values for the instruction at the current PC. The block updates the PC on every clock edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` holds the parameter `RESET_VEC` (default 0xBFC0_0000).
- R2: On every rising clock edge with `rst_n` high, `pc` takes the value that `next_pc` showed before that edge. For any opcode that is not a branch or jump, or for opcode 0 with a function code other than 8 or 9, `next_pc` is `pc`+4, wrapping modulo 2^32.
- R3: Opcode 6'b000100 (branch-if-equal): when `rs_val` equals `rt_val`, `next_pc` is `pc`+4 plus the sign-extended `imm` shifted left by two; otherwise it is `pc`+4.
- R4: Opcode 6'b000101 (branch-if-not-equal): the branch is taken when `rs_val` differs from `rt_val`, with the same target arithmetic as R3; otherwise `next_pc` is `pc`+4.
- R5: Opcode 6'b000010 (jump): `next_pc` is bits 31:28 of `pc`+4, then `target`, then two zero bits.
- R6: Opcode 6'b000011 (jump-and-link): `next_pc` follows R5, `link_we` is 1, `link_dst` is 31, and `link_data` is `pc`+8.
- R7: Opcode 0 with `funct` 6'b001000 (jump-register): `next_pc` equals `rs_val`, and no link is written.
- R8: Opcode 0 with `funct` 6'b001001 (jump-and-link-register): `next_pc` equals `rs_val`, `link_dst` equals `rd`, `link_data` is `pc`+8, and `link_we` is 1 unless R10 applies.
- R9: When `exc_req` is 1, `next_pc` is the parameter `EXC_VEC` (default 0x0000_1100) and `link_we` is 0, whatever the instruction fields hold.
- R10: A jump-and-link-register with `rd` equal to 0 leaves `link_we` at 0.
- R11: `link_we` is 0 for every instruction other than the two link forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Primary opcode of the instruction at `pc` |
| funct | input | 6 | Function code, used when the opcode is 0 |
| rd | input | 5 | Destination register field |
| imm | input | 16 | Branch offset in words, signed |
| target | input | 26 | Absolute jump target field |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| exc_req | input | 1 | Exception redirect request |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the next cycle |
| link_we | output | 1 | Return-address write enable |
| link_dst | output | 5 | Return-address destination register |
| link_data | output | 32 | Return address, `pc`+8 |

## Verification
The sweep loads the PC through jump-register to several addresses. These include the top of the address space, where `pc`+4 wraps, and the word just below a 256 MB region boundary, where the jump target must take its high nibble from `pc`+4 rather than from `pc`. A design that used `pc` for the high bits would jump into the wrong region. A design that zero-extended the offset would branch forward on 0x8000 and 0xFFFF. The bench crosses every opcode and every function code with equal and unequal operands, link destinations 0, 5 and 31, and an asserted exception. This catches a design that writes PC+4 as the link, writes register 0, lets a branch beat the exception, or decodes a neighbouring function code as a jump.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] EXC_VEC   = 32'h0000_1100,
  parameter logic [4:0]  LINK_REG  = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic [4:0]  rd,
  input  logic [15:0] imm,
  input  logic [25:0] target,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic        exc_req,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_dst,
  output logic [31:0] link_data
);
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_J       = 6'b000010;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] FN_JR      = 6'b001000;
  localparam logic [5:0] FN_JALR    = 6'b001001;

  logic [31:0] seq_pc, br_pc, abs_pc;
  logic        is_beq, is_bne, is_j, is_jal, is_jr, is_jalr;
  logic        operands_eq, take_br;

  assign seq_pc  = pc + 32'd4;
  assign br_pc   = seq_pc + {{14{imm[15]}}, imm, 2'b00};
  assign abs_pc  = {seq_pc[31:28], target, 2'b00};

  assign is_beq  = opcode == OP_BEQ;
  assign is_bne  = opcode == OP_BNE;
  assign is_j    = opcode == OP_J;
  assign is_jal  = opcode == OP_JAL;
  assign is_jr   = (opcode == OP_SPECIAL) && (funct == FN_JR);
  assign is_jalr = (opcode == OP_SPECIAL) && (funct == FN_JALR);

  assign operands_eq = rs_val == rt_val;
  assign take_br     = (is_beq && operands_eq) || (is_bne && !operands_eq);

  always_comb begin
    if (exc_req)                next_pc = EXC_VEC;
    else if (is_jr || is_jalr)  next_pc = rs_val;
    else if (is_j || is_jal)    next_pc = abs_pc;
    else if (take_br)           next_pc = br_pc;
    else                        next_pc = seq_pc;
  end

  assign link_dst  = is_jal ? LINK_REG : rd;
  assign link_data = pc + 32'd8;
  assign link_we   = !exc_req && (is_jal || is_jalr) && (link_dst != 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_VEC;
    else        pc <= next_pc;
  end

  AST_PC_FOLLOWS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pc == $past(next_pc));  // R2
  AST_EXC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> pc == EXC_VEC);  // R9
  AST_EXC_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !link_we);  // R9
  AST_NO_ZERO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_dst != 5'd0);  // R10
  AST_LINK_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> $past(link_data) == $past(pc) + 32'd8);  // R6
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam time CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'hBFC0_0000;
  localparam logic [31:0] EV = 32'h0000_1100;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  rd = '0;
  logic [15:0] imm = '0;
  logic [25:0] target = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        exc_req = 1'b0;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_dst;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .rd(rd),
    .imm(imm), .target(target), .rs_val(rs_val), .rt_val(rt_val),
    .exc_req(exc_req), .pc(pc), .next_pc(next_pc), .link_we(link_we),
    .link_dst(link_dst), .link_data(link_data)
  );

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (pc %h op %b fn %b)",
               tag, what, act, exp, pc, opcode, funct);
    end
  endtask

  task automatic set_pc(logic [31:0] v);
    opcode = 6'b000000; funct = 6'b001000; rs_val = v; exc_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check32("R7", "pc after jump-register", pc, v);
  endtask

  task automatic apply(logic [31:0] p, logic [5:0] op, logic [5:0] fn, logic [4:0] d,
                       logic [15:0] im, logic [25:0] tg, logic [31:0] a,
                       logic [31:0] b, logic ex);
    logic [31:0] s4, e_npc;
    logic        e_we;
    logic [4:0]  e_dst;
    string       t_npc, t_we;
    set_pc(p);
    opcode = op; funct = fn; rd = d; imm = im; target = tg;
    rs_val = a; rt_val = b; exc_req = ex;
    s4 = p + 32'd4;
    e_npc = s4; e_we = 1'b0; e_dst = d; t_npc = "R2"; t_we = "R11";
    if (op == 6'd4) begin
      t_npc = "R3";
      if (a == b) e_npc = s4 + 32'(signed'(im)) * 4;
    end else if (op == 6'd5) begin
      t_npc = "R4";
      if (a != b) e_npc = s4 + 32'(signed'(im)) * 4;
    end else if (op == 6'd2) begin
      t_npc = "R5"; e_npc = (s4 & 32'hF000_0000) | (32'(tg) * 4);
    end else if (op == 6'd3) begin
      t_npc = "R6"; t_we = "R6"; e_npc = (s4 & 32'hF000_0000) | (32'(tg) * 4);
      e_we = 1'b1; e_dst = 5'd31;
    end else if (op == 6'd0 && fn == 6'd8) begin
      t_npc = "R7"; t_we = "R7"; e_npc = a;
    end else if (op == 6'd0 && fn == 6'd9) begin
      t_npc = "R8"; e_npc = a;
      if (d == 5'd0) t_we = "R10";
      else begin t_we = "R8"; e_we = 1'b1; end
    end
    if (ex) begin
      t_npc = "R9"; t_we = "R9"; e_npc = EV; e_we = 1'b0;
    end
    #1;
    check32(t_npc, "next_pc", next_pc, e_npc);
    check32(t_we, "link_we", 32'(link_we), 32'(e_we));
    if (e_we) begin
      check32(t_we, "link_dst", 32'(link_dst), 32'(e_dst));
      check32(t_we, "link_data", link_data, p + 32'd8);
    end
    @(posedge clk); @(negedge clk);
    check32("R2", "pc after edge", pc, e_npc);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pcs [6];
    logic [15:0] imms [5];
    logic [4:0]  rds [3];
    pcs = '{32'h0000_0000, 32'h0FFF_FFF8, 32'h0FFF_FFFC, 32'h7FFF_0000,
            32'hFFFF_FFFC, 32'h1234_5678};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    rds = '{5'd0, 5'd5, 5'd31};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1", "pc in reset", pc, RV);
    @(posedge clk);
    check32("R1", "pc held in reset", pc, RV);
    @(negedge clk);
    rst_n = 1'b1;
    opcode = 6'b100011; exc_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check32("R2", "first sequential step", pc, RV + 32'd4);
    for (int pi = 0; pi < 6; pi++) begin
      for (int op = 0; op < 64; op++) begin
        for (int fn = 0; fn < ((op == 0) ? 64 : 1); fn++) begin
          for (int v = 0; v < 8; v++) begin
            logic [31:0] a;
            a = (pcs[pi] ^ 32'h5A5A_1234) + 32'(v) * 32'h0101_0011;
            apply(pcs[pi], 6'(op), (op == 0) ? 6'(fn) : 6'(v * 7), rds[v % 3],
                  imms[v % 5], 26'h2AB_CDEF ^ 26'(v * 13), a,
                  v[0] ? a : a ^ 32'h0001_0000, v == 7);
          end
        end
      end
    end
    rst_n = 1'b0;
    #1;
    check32("R1", "pc on reset reassert", pc, RV);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule